// File: doc/BRIEF.md
# Multi-Function PCI Configuration Header

This block holds the predefined configuration header registers for up to three PCI functions. Each physical function has its own copy of the identity, command, status, class, header-type, BIST and first base-address registers. A host-side configuration port carries a function number, a dword address inside the 256-byte header, byte enables and write data. Read data comes back registered, one cycle after the request.

A local controller sets the block up during initialisation. It can overwrite each function's vendor/device dword and its class/revision dword, and it can load an enable mask that removes functions. The remaining functions are packed in ascending physical order, so the host always sees them as a contiguous set starting at function 0.

Once the controller raises its init-done input, the identity fields and the enable mask are frozen. Until then the host sees only all-ones and cannot change anything. The first base-address register claims a prefetchable memory window whose size is a parameter, and its low bits are fixed so the host can size it.

Top module: `pci_cfg_header`

## Requirements
- R1: After reset, `cfg_rvalid` and `cfg_rdata` are 0. Each function's header reads dword 0 = 0x219211D4, dword 2 = 0x07800000 (class 0x078000, revision 0x00), command 0, latency timer 0 and BAR 0x00000008.
- R2: Before init-done has been seen, every host read returns 0xFFFFFFFF and host writes change no register.
- R3: Host function number n selects the n-th enabled physical function, counted upward from physical function 0 over the mask bits that are set (mask bit p enables physical function p). Reset mask is all ones.
- R4: A host access whose function number is not below the number of enabled functions reads 0xFFFFFFFF and writes nothing.
- R5: Local identity writes land only before init-done. Select 0 loads dword 0 ({device, vendor}) and select 1 loads dword 2 ({class, revision}) of the named physical function. After init-done, local identity writes and enable-mask writes are ignored.
- R6: In dword 1, only bits [2:0] of the command word (I/O space, memory space, bus master) are writable, through byte enable 0. All other command bits read 0.
- R7: The upper half of dword 1 (status) always reads 0x0290 (capabilities list, fast back-to-back capable, medium DEVSEL) and ignores host writes.
- R8: Dword 3 reads {BIST 0x00, header type 0x80, latency timer, cache line size 0x00}. Only the latency timer (bits 15:8, byte enable 1) is writable.
- R9: In dword 4 (BAR), bits 31:BAR_LOG2 are writable per byte enable, and bits BAR_LOG2-1:0 read 0x008 with the default 4 KB window. Writing all ones reads back 0xFFFFF008.
- R10: A read's data appears on `cfg_rdata` with `cfg_rvalid` high in the cycle after the request. Dwords 0 and 2 are read-only to the host, and dwords 5 to 63 read 0.
- R11: `cfg_rvalid` is low in the cycle after a write request and after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Host configuration access strobe, one cycle |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_fn | input | FN_W | Host function number |
| cfg_dw | input | DWA_W | Dword address within the header |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Registered read data |
| cfg_rvalid | output | 1 | Read data valid |
| loc_id_we | input | 1 | Local identity write strobe |
| loc_id_sel | input | 1 | 0 = {device, vendor}, 1 = {class, revision} |
| loc_fn | input | FN_W | Physical function for the local write |
| loc_id_data | input | 32 | Local identity data |
| loc_mask_we | input | 1 | Load the function enable mask |
| loc_mask | input | NUM_FUNC | New enable mask |
| loc_init_done | input | 1 | Initialisation complete (latched) |

## Verification
The bench goes after masks with holes: with functions 0 and 2 enabled, a mapping that ignored the mask would show physical function 1's identity as host function 1. It then probes function numbers at and above the enabled count, where a missing bound check would expose a disabled or nonexistent register set. It sizes the BAR with all ones and writes with partial or empty byte enables, which catch low bits that can be written and bytes written without their enable. It also tries identity and mask writes after init-done and host accesses before it; a frozen gate that was missing would let either one leak through.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int DW_IDENT   = 0;
  localparam int DW_CMDSTAT = 1;
  localparam int DW_CLASS   = 2;
  localparam int DW_MISC    = 3;
  localparam int DW_BAR0    = 4;

  localparam logic [15:0] STATUS_RO = 16'h0290;
  localparam logic [7:0]  HDR_TYPE  = 8'h80;
  localparam logic [7:0]  CLS_RO    = 8'h00;
  localparam logic [7:0]  BIST_RO   = 8'h00;
  localparam int          CMD_BITS  = 3;

  typedef enum logic {LSEL_IDENT = 1'b0, LSEL_CLASS = 1'b1} loc_sel_e;
endpackage

// File: rtl/pci_cfg_fmap.sv
module pci_cfg_fmap #(
  parameter int NUM_FUNC = 3,
  parameter int FN_W     = 2,
  parameter int CNT_W    = 2
) (
  input  logic [NUM_FUNC-1:0]              en_mask,
  output logic [CNT_W-1:0]                 fn_count,
  output logic [(2**FN_W)-1:0][FN_W-1:0]   phys_map
);
  localparam int NSLOT = 2**FN_W;

  always_comb begin
    logic [CNT_W-1:0] cnt;
    cnt      = '0;
    phys_map = '0;
    for (int p = 0; p < NUM_FUNC; p++) begin
      if (en_mask[p]) begin
        for (int s = 0; s < NSLOT; s++) begin
          if (cnt == CNT_W'(s)) phys_map[s] = FN_W'(p);
        end
        cnt = cnt + 1'b1;
      end
    end
    fn_count = cnt;
  end
endmodule

// File: rtl/pci_cfg_func.sv
module pci_cfg_func
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0] VID_RST   = 16'h11D4,
  parameter logic [15:0] DID_RST   = 16'h2192,
  parameter logic [7:0]  REV_RST   = 8'h00,
  parameter logic [23:0] CLASS_RST = 24'h078000,
  parameter int          BAR_LOG2  = 12,
  parameter int          DWA_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [DWA_W-1:0] host_dw,
  input  logic [3:0]       host_be,
  input  logic [31:0]      host_wdata,
  input  logic             loc_we,
  input  logic             loc_sel,
  input  logic [31:0]      loc_wdata,
  output logic [31:0]      rd_word
);
  localparam int BAR_HW = 32 - BAR_LOG2;
  localparam logic [BAR_LOG2-1:0] BAR_LOW = BAR_LOG2'(4'b1000);

  logic [15:0]         vid_q, did_q;
  logic [7:0]          rev_q, lat_q;
  logic [23:0]         cls_q;
  logic [CMD_BITS-1:0] cmd_q;
  logic [BAR_HW-1:0]   bar_q;
  logic [31:0]         bar_merge;

  always_comb begin
    bar_merge = {bar_q, BAR_LOW};
    for (int b = 0; b < 4; b++) begin
      if (host_be[b]) bar_merge[8*b +: 8] = host_wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_q <= VID_RST;
      did_q <= DID_RST;
      rev_q <= REV_RST;
      cls_q <= CLASS_RST;
    end else if (loc_we) begin
      if (loc_sel == LSEL_IDENT) begin
        vid_q <= loc_wdata[15:0];
        did_q <= loc_wdata[31:16];
      end else begin
        rev_q <= loc_wdata[7:0];
        cls_q <= loc_wdata[31:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      lat_q <= '0;
      bar_q <= '0;
    end else if (host_we) begin
      case (int'(host_dw))
        DW_CMDSTAT: if (host_be[0]) cmd_q <= host_wdata[CMD_BITS-1:0];
        DW_MISC:    if (host_be[1]) lat_q <= host_wdata[15:8];
        DW_BAR0:    bar_q <= bar_merge[31:BAR_LOG2];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (int'(host_dw))
      DW_IDENT:   rd_word = {did_q, vid_q};
      DW_CMDSTAT: rd_word = {STATUS_RO, {(16-CMD_BITS){1'b0}}, cmd_q};
      DW_CLASS:   rd_word = {cls_q, rev_q};
      DW_MISC:    rd_word = {BIST_RO, HDR_TYPE, lat_q, CLS_RO};
      DW_BAR0:    rd_word = {bar_q, BAR_LOW};
      default:    rd_word = '0;
    endcase
  end
endmodule

// File: rtl/pci_cfg_header.sv
module pci_cfg_header #(
  parameter int          NUM_FUNC  = 3,
  parameter int          FN_W      = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1,
  parameter int          DWA_W     = 6,
  parameter int          BAR_LOG2  = 12,
  parameter logic [15:0] VID_RST   = 16'h11D4,
  parameter logic [15:0] DID_RST   = 16'h2192,
  parameter logic [7:0]  REV_RST   = 8'h00,
  parameter logic [23:0] CLASS_RST = 24'h078000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_req,
  input  logic                cfg_wr,
  input  logic [FN_W-1:0]     cfg_fn,
  input  logic [DWA_W-1:0]    cfg_dw,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                cfg_rvalid,
  input  logic                loc_id_we,
  input  logic                loc_id_sel,
  input  logic [FN_W-1:0]     loc_fn,
  input  logic [31:0]         loc_id_data,
  input  logic                loc_mask_we,
  input  logic [NUM_FUNC-1:0] loc_mask,
  input  logic                loc_init_done
);
  localparam int NSLOT = 2**FN_W;
  localparam int CNT_W = $clog2(NUM_FUNC + 1);

  logic                          init_q;
  logic [NUM_FUNC-1:0]           mask_q;
  logic [CNT_W-1:0]              fn_count;
  logic [NSLOT-1:0][FN_W-1:0]    phys_map;
  logic [FN_W-1:0]               phys_sel;
  logic                          host_ok;
  logic [31:0]                   rd_words [NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= 1'b0;
      mask_q <= '1;
    end else begin
      if (loc_init_done) init_q <= 1'b1;
      if (loc_mask_we && !init_q) mask_q <= loc_mask;
    end
  end

  pci_cfg_fmap #(.NUM_FUNC(NUM_FUNC), .FN_W(FN_W), .CNT_W(CNT_W)) u_fmap (
    .en_mask  (mask_q),
    .fn_count (fn_count),
    .phys_map (phys_map)
  );

  assign phys_sel = phys_map[cfg_fn];
  assign host_ok  = init_q && (int'(cfg_fn) < int'(fn_count));

  for (genvar p = 0; p < NSLOT; p++) begin : g_fn
    if (p < NUM_FUNC) begin : g_real
      logic hwe, lwe;
      assign hwe = cfg_req && cfg_wr && host_ok && (phys_sel == FN_W'(p));
      assign lwe = loc_id_we && !init_q && (loc_fn == FN_W'(p));
      pci_cfg_func #(
        .VID_RST(VID_RST), .DID_RST(DID_RST), .REV_RST(REV_RST),
        .CLASS_RST(CLASS_RST), .BAR_LOG2(BAR_LOG2), .DWA_W(DWA_W)
      ) u_func (
        .clk        (clk),
        .rst        (rst),
        .host_we    (hwe),
        .host_dw    (cfg_dw),
        .host_be    (cfg_be),
        .host_wdata (cfg_wdata),
        .loc_we     (lwe),
        .loc_sel    (loc_id_sel),
        .loc_wdata  (loc_id_data),
        .rd_word    (rd_words[p])
      );
    end else begin : g_none
      assign rd_words[p] = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata  <= '0;
      cfg_rvalid <= 1'b0;
    end else begin
      cfg_rvalid <= cfg_req && !cfg_wr;
      if (cfg_req && !cfg_wr) cfg_rdata <= host_ok ? rd_words[phys_sel] : '1;
    end
  end
endmodule

// File: rtl/pci_cfg_header_chk.sv
module pci_cfg_header_chk #(
  parameter int NUM_FUNC = 3,
  parameter int DWA_W    = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_req,
  input logic                cfg_wr,
  input logic [DWA_W-1:0]    cfg_dw,
  input logic [31:0]         cfg_rdata,
  input logic                cfg_rvalid,
  input logic                init_q,
  input logic [NUM_FUNC-1:0] mask_q
);
  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_wr) |=> cfg_rvalid);

  // R11
  no_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_req && !cfg_wr) |=> !cfg_rvalid);

  // R2
  preinit_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_wr && !init_q) |=> (cfg_rdata == 32'hFFFF_FFFF));

  // R7
  status_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_wr && cfg_dw == DWA_W'(1)) |=>
      (cfg_rdata[31:16] == 16'h0290 || cfg_rdata == 32'hFFFF_FFFF));

  // R8
  misc_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_wr && cfg_dw == DWA_W'(3)) |=>
      ((cfg_rdata[31:16] == 16'h0080 && cfg_rdata[7:0] == 8'h00) || cfg_rdata == 32'hFFFF_FFFF));

  // R9
  bar_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_wr && cfg_dw == DWA_W'(4)) |=>
      (cfg_rdata[3:0] == 4'h8 || cfg_rdata == 32'hFFFF_FFFF));

  // R5
  mask_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    init_q |=> ($stable(mask_q) && init_q));
endmodule

bind pci_cfg_header pci_cfg_header_chk #(.NUM_FUNC(NUM_FUNC), .DWA_W(DWA_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
  .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .init_q(init_q), .mask_q(mask_q)
);

// File: tb/pci_cfg_header_test.sv
module pci_cfg_header_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_req = 0, cfg_wr = 0;
  logic [1:0]  cfg_fn = 0;
  logic [5:0]  cfg_dw = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic        loc_id_we = 0, loc_id_sel = 0;
  logic [1:0]  loc_fn = 0;
  logic [31:0] loc_id_data = 0;
  logic        loc_mask_we = 0;
  logic [2:0]  loc_mask = 0;
  logic        loc_init_done = 0;

  int checks = 0;
  int fails  = 0;

  logic [15:0] m_vid [NF];
  logic [15:0] m_did [NF];
  logic [7:0]  m_rev [NF];
  logic [23:0] m_cls [NF];
  logic [2:0]  m_cmd [NF];
  logic [7:0]  m_lat [NF];
  logic [31:0] m_bar [NF];
  logic [2:0]  m_mask;
  bit          m_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_cfg_header uut (
    .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_fn(cfg_fn),
    .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .loc_id_we(loc_id_we), .loc_id_sel(loc_id_sel),
    .loc_fn(loc_fn), .loc_id_data(loc_id_data), .loc_mask_we(loc_mask_we),
    .loc_mask(loc_mask), .loc_init_done(loc_init_done)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic int m_count();
    int c = 0;
    for (int p = 0; p < NF; p++) if (m_mask[p]) c++;
    return c;
  endfunction

  function automatic int m_phys(input int fn);
    int c = 0;
    for (int p = 0; p < NF; p++) begin
      if (m_mask[p]) begin
        if (c == fn) return p;
        c++;
      end
    end
    return 0;
  endfunction

  function automatic logic [31:0] exp_rd(input int fn, input int dw);
    int p;
    if (!m_done || fn >= m_count()) return 32'hFFFF_FFFF;
    p = m_phys(fn);
    case (dw)
      0: return {m_did[p], m_vid[p]};
      1: return {16'h0290, 13'h0, m_cmd[p]};
      2: return {m_cls[p], m_rev[p]};
      3: return {8'h00, 8'h80, m_lat[p], 8'h00};
      4: return {m_bar[p][31:12], 12'h008};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for(input int fn, input int dw);
    if (!m_done) return "R2";
    if (fn >= m_count()) return "R4";
    case (dw)
      0, 2: return "R1";
      1: return "R6";
      3: return "R8";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model_wr(input int fn, input int dw, input logic [3:0] be, input logic [31:0] wd);
    int p;
    if (!m_done || fn >= m_count()) return;
    p = m_phys(fn);
    case (dw)
      1: if (be[0]) m_cmd[p] = wd[2:0];
      3: if (be[1]) m_lat[p] = wd[15:8];
      4: begin
        for (int b = 0; b < 4; b++) if (be[b]) m_bar[p][8*b +: 8] = wd[8*b +: 8];
        m_bar[p][11:0] = 12'h0;
      end
      default: ;
    endcase
  endtask

  task automatic host_op(input bit wr, input int fn, input int dw, input logic [3:0] be,
                         input logic [31:0] wd, input string tag);
    logic [31:0] exp;
    exp = exp_rd(fn, dw);
    @(negedge clk);
    cfg_req = 1'b1; cfg_wr = wr; cfg_fn = fn[1:0]; cfg_dw = dw[5:0];
    cfg_be = be; cfg_wdata = wd;
    @(negedge clk);
    cfg_req = 1'b0; cfg_wr = 1'b0;
    if (wr) begin
      model_wr(fn, dw, be, wd);
      check({31'h0, cfg_rvalid}, 32'h0, "R11 rvalid after write");
    end else begin
      check({31'h0, cfg_rvalid}, 32'h1, "R10 rvalid after read");
      check(cfg_rdata, exp, tag);
    end
  endtask

  task automatic loc_ident(input int p, input bit sel, input logic [31:0] d);
    @(negedge clk);
    loc_id_we = 1'b1; loc_id_sel = sel; loc_fn = p[1:0]; loc_id_data = d;
    @(negedge clk);
    loc_id_we = 1'b0;
    if (!m_done) begin
      if (!sel) begin m_vid[p] = d[15:0]; m_did[p] = d[31:16]; end
      else begin m_rev[p] = d[7:0]; m_cls[p] = d[31:8]; end
    end
  endtask

  task automatic loc_set_mask(input logic [2:0] m);
    @(negedge clk);
    loc_mask_we = 1'b1; loc_mask = m;
    @(negedge clk);
    loc_mask_we = 1'b0;
    if (!m_done) m_mask = m;
  endtask

  task automatic loc_finish();
    @(negedge clk);
    loc_init_done = 1'b1;
    @(negedge clk);
    loc_init_done = 1'b0;
    m_done = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < NF; p++) begin
      m_vid[p] = 16'h11D4; m_did[p] = 16'h2192; m_rev[p] = 8'h00;
      m_cls[p] = 24'h078000; m_cmd[p] = 3'h0; m_lat[p] = 8'h00; m_bar[p] = 32'h0;
    end
    m_mask = 3'b111;
    m_done = 1'b0;
    check(cfg_rdata, 32'h0, "R1 rdata after reset");
    check({31'h0, cfg_rvalid}, 32'h0, "R1 rvalid after reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));

    // Round A: mask with a hole (functions 0 and 2)
    do_reset();
    host_op(0, 0, 0, 4'hF, 0, "R2 read before init");
    host_op(1, 0, 1, 4'hF, 32'hFFFF_FFFF, "R2 write before init");
    loc_ident(1, 0, 32'hDEAD_BEEF);
    loc_ident(2, 0, 32'hABCD_1234);
    loc_ident(2, 1, 32'h0C03_3007);
    loc_set_mask(3'b101);
    loc_finish();
    loc_ident(0, 0, 32'h7777_8888);
    loc_set_mask(3'b111);
    host_op(0, 0, 1, 4'hF, 0, "R2 command untouched by pre-init write");
    host_op(0, 0, 0, 4'hF, 0, "R1 default ident / R5 post-init write ignored");
    host_op(0, 0, 2, 4'hF, 0, "R1 default class");
    host_op(0, 0, 3, 4'hF, 0, "R1 R8 misc dword");
    host_op(0, 0, 4, 4'hF, 0, "R1 default BAR");
    host_op(0, 1, 0, 4'hF, 0, "R3 fn1 maps to physical 2");
    host_op(0, 1, 2, 4'hF, 0, "R3 R5 class on physical 2");
    host_op(0, 2, 0, 4'hF, 0, "R4 R5 fn2 absent, mask frozen");
    host_op(0, 3, 0, 4'hF, 0, "R4 fn3 absent");
    host_op(1, 2, 3, 4'hF, 32'hFFFF_FFFF, "R4 write to absent fn");
    host_op(1, 0, 4, 4'hF, 32'hFFFF_FFFF, "R9 BAR sizing write");
    host_op(0, 0, 4, 4'hF, 0, "R9 BAR sizing readback");
    host_op(1, 0, 4, 4'b0100, 32'h0012_3456, "R9 BAR partial write");
    host_op(0, 0, 4, 4'hF, 0, "R9 BAR byte enable");
    host_op(1, 0, 1, 4'hF, 32'hFFFF_FFFF, "R6 command all ones");
    host_op(0, 0, 1, 4'hF, 0, "R6 R7 command bits and status");
    host_op(1, 0, 1, 4'h0, 32'h0000_0000, "R6 empty byte enable");
    host_op(0, 0, 1, 4'hF, 0, "R6 empty byte enable no effect");
    host_op(1, 1, 3, 4'b0001, 32'h0000_5A00, "R8 latency without enable");
    host_op(0, 1, 3, 4'hF, 0, "R8 latency unchanged");
    host_op(1, 1, 3, 4'hF, 32'hFFFF_A5FF, "R8 latency write");
    host_op(0, 1, 3, 4'hF, 0, "R8 latency readback");
    host_op(1, 1, 0, 4'hF, 32'h0, "R10 host ident write");
    host_op(0, 1, 0, 4'hF, 0, "R10 ident read-only to host");
    host_op(0, 0, 9, 4'hF, 0, "R10 reserved dword");

    // Round B: single function, physical 2 only
    do_reset();
    loc_ident(2, 0, 32'h55AA_1357);
    loc_set_mask(3'b100);
    loc_finish();
    host_op(0, 0, 0, 4'hF, 0, "R3 single fn packs to 0");
    host_op(0, 1, 0, 4'hF, 0, "R4 fn1 absent with one fn");
    host_op(0, 0, 3, 4'hF, 0, "R8 misc single fn");

    // Round C: all functions, random traffic
    do_reset();
    loc_ident(0, 1, 32'h0401_0002);
    loc_finish();
    for (int i = 0; i < 800; i++) begin
      int fn, dw, sel;
      bit wr;
      logic [3:0] be;
      logic [31:0] wd;
      fn  = int'($urandom % 4);
      sel = int'($urandom % 8);
      dw  = (sel < 6) ? sel : int'($urandom % 64);
      wr  = bit'($urandom % 2);
      be  = 4'($urandom);
      wd  = $urandom;
      host_op(wr, fn, dw, be, wd, tag_for(fn, dw));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule